// File: doc/BRIEF.md
# Edge-Triggered Port Interrupt Controller

This block monitors an eight-pin input port and turns selected signal transitions into interrupt requests. Each pin carries its own edge-select bit, mask bit and sticky pending bit. The edge-select bit picks rising or falling transitions as the active edge. The same bit also picks whether the pad should be pulled low or pulled high. The pins are asynchronous to the block clock, so each pin passes through a synchronizer before the edges are compared.

Software reaches the three per-pin registers through a flat word-wide register interface. A write to the pending register clears only the bit positions that carry a one. All pending bits that are unmasked combine into a single registered interrupt line.

Top module: `edge_irq_port`

## Requirements
- R1: After reset the edge-select, mask and pending registers all read 0x00, `irq_o` is 0, `pull_up_o` is 0xFF and `pull_dn_o` is 0x00.
- R2: A transition that reaches `pin_i` before clock edge k sets the pending bit at edge k+2. It is visible on read after edge k+2 and not after edge k+1.
- R3: With edge-select bit 1, a rising transition of the pin sets its pending bit and a falling one does not. With edge-select bit 0, the reverse holds.
- R4: Writing to address 2 clears each pending bit written as 1. A pending bit written as 0 keeps its value.
- R5: If an active edge and a clearing write reach the same pending bit in the same cycle, the bit is 1 afterwards.
- R6: `irq_o` is 1 in the cycle after any pending bit is 1 while its mask bit is 1. In every other case it is 0 in the next cycle.
- R7: Writing the edge-select register while the pins are steady sets no pending bit.
- R8: `pull_dn_o` equals the edge-select register and `pull_up_o` is its bitwise inverse. Bit 1 selects a pull-down and bit 0 selects a pull-up.
- R9: Register addresses are 0 = edge-select, 1 = mask and 2 = pending. Address 3 reads 0x00 and ignores writes. Reads are combinational on `addr_i`, and every register is writable in any cycle.
- R10: A pending bit stays set after its pin returns to its earlier level, until software clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Port pins, asynchronous to the clock |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| irq_o | output | 1 | Combined registered interrupt request |
| pull_up_o | output | 8 | Per-pin pull-up select |
| pull_dn_o | output | 8 | Per-pin pull-down select |

## Verification
The checker assumes that pins come out of reset low, because the synchronizer stages and the previous-value stage all start at 0. A pin held high through reset would look like a rising edge on the first cycles. The bench therefore drives every pin to 0 before releasing reset. It changes pins and register inputs only on the falling clock edge, so each transition lands at a known rising edge. The set-wins case depends on a clearing write and a detected edge landing in the same cycle. The bench counts synchronizer stages to place the write exactly there.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_POL  = 2'd0,
    REG_EN   = 2'd1,
    REG_FLAG = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[0] <= '0;
        else         stage_q[0] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/edge_irq_detect.sv
module edge_irq_detect #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] pol_i,
  output logic [WIDTH-1:0] hit_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;
  end

  // only input transitions count; polarity alone never produces a hit
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic rise, fall;
    assign rise     = sync_i[i] & ~prev_q[i];
    assign fall     = ~sync_i[i] & prev_q[i];
    assign hit_o[i] = pol_i[i] ? rise : fall;
  end
endmodule

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
  import edge_irq_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic [WIDTH-1:0]  hit_i,
  output logic [WIDTH-1:0]  pol_o,
  output logic [WIDTH-1:0]  en_o,
  output logic [WIDTH-1:0]  flag_o,
  output logic [WIDTH-1:0]  clr_o,
  output logic [WIDTH-1:0]  rdata_o
);
  reg_sel_e         sel;
  logic [WIDTH-1:0] pol_q, en_q, flag_q, flag_d;

  assign sel = reg_sel_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q <= '0;
      en_q  <= '0;
    end else if (wr_en_i) begin
      if (sel == REG_POL) pol_q <= wdata_i;
      if (sel == REG_EN)  en_q  <= wdata_i;
    end
  end

  assign clr_o = (wr_en_i && sel == REG_FLAG) ? wdata_i : '0;

  // set dominates clear
  assign flag_d = (flag_q & ~clr_o) | hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  always_comb begin
    unique case (sel)
      REG_POL:  rdata_o = pol_q;
      REG_EN:   rdata_o = en_q;
      REG_FLAG: rdata_o = flag_q;
      default:  rdata_o = '0;
    endcase
  end

  assign pol_o  = pol_q;
  assign en_o   = en_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/edge_irq_reduce.sv
module edge_irq_reduce #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] flag_i,
  input  logic [WIDTH-1:0] en_i,
  output logic             irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(flag_i & en_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/edge_irq_port.sv
module edge_irq_port
  import edge_irq_pkg::*;
#(
  parameter int unsigned N_PINS      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] rdata_o,
  output logic              irq_o,
  output logic [N_PINS-1:0] pull_up_o,
  output logic [N_PINS-1:0] pull_dn_o
);
  logic [N_PINS-1:0] sync_q, hit, pol, en, flag, clr_mask;

  edge_irq_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(pin_i), .sync_o(sync_q)
  );

  edge_irq_detect #(.WIDTH(N_PINS)) u_detect (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_q), .pol_i(pol), .hit_o(hit)
  );

  edge_irq_regs #(.WIDTH(N_PINS)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .hit_i(hit), .pol_o(pol), .en_o(en), .flag_o(flag),
    .clr_o(clr_mask), .rdata_o(rdata_o)
  );

  edge_irq_reduce #(.WIDTH(N_PINS)) u_reduce (
    .clk_i(clk_i), .rst_ni(rst_ni), .flag_i(flag), .en_i(en), .irq_o(irq_o)
  );

  // pull device follows the idle level implied by the active edge
  assign pull_dn_o = pol;
  assign pull_up_o = ~pol;
endmodule

// File: rtl/edge_irq_port_chk.sv
module edge_irq_port_chk #(
  parameter int unsigned N_PINS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_PINS-1:0] sync_q,
  input logic [N_PINS-1:0] hit,
  input logic [N_PINS-1:0] en,
  input logic [N_PINS-1:0] flag,
  input logic [N_PINS-1:0] clr_mask,
  input logic              irq_o
);
  // R6: registered combine
  a_r6_irq_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(flag & en)) |=> irq_o);
  a_r6_irq_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(flag & en)) |=> !irq_o);

  for (genvar i = 0; i < N_PINS; i++) begin : g_bit
    // R5: set beats clear
    a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit[i] |=> flag[i]);
    // R4: clear without concurrent edge
    a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_mask[i] && !hit[i]) |=> !flag[i]);
    // R10: sticky without clear
    a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag[i] && !clr_mask[i]) |=> flag[i]);
    // R7: steady synchronized input never sets a flag
    a_r7_no_edge_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($stable(sync_q[i]) && !flag[i]) |=> !flag[i]);
  end
endmodule

bind edge_irq_port edge_irq_port_chk #(.N_PINS(N_PINS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sync_q(sync_q), .hit(hit), .en(en),
  .flag(flag), .clr_mask(clr_mask), .irq_o(irq_o)
);

// File: tb/edge_irq_port_tb.sv
module edge_irq_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam logic [1:0] A_POL = 2'd0, A_EN = 2'd1, A_FLAG = 2'd2, A_NONE = 2'd3;

  typedef struct packed {
    logic [7:0] pol;
    logic [7:0] en;
    logic [7:0] start;
    logic [7:0] fin;
    logic [7:0] exp_flag;
    logic       exp_irq;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{8'hFF, 8'hFF, 8'h00, 8'h0F, 8'h0F, 1'b1},
    '{8'h00, 8'hF0, 8'hFF, 8'h3C, 8'hC3, 1'b1},
    '{8'h0F, 8'h0F, 8'hF0, 8'h0F, 8'hFF, 1'b1},
    '{8'hAA, 8'h55, 8'h00, 8'hFF, 8'hAA, 1'b0},
    '{8'h55, 8'hFF, 8'h55, 8'h55, 8'h00, 1'b0}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin = '0;
  logic         wr_en = 1'b0;
  logic [1:0]   addr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata, pull_up, pull_dn;
  logic         irq;
  int           checks = 0;
  int           failures = 0;
  bit           done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_irq_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .pull_up_o(pull_up),
    .pull_dn_o(pull_dn)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [N-1:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [N-1:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  logic [N-1:0] v;

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(1);

    // R1 reset state
    rd(A_POL, v);  check("R1 pol", v, 8'h00);
    rd(A_EN, v);   check("R1 en", v, 8'h00);
    rd(A_FLAG, v); check("R1 flag", v, 8'h00);
    check("R1 irq", irq, 0);
    check("R1 pull_up", pull_up, 8'hFF);
    check("R1 pull_dn", pull_dn, 8'h00);

    // R9 readback and unused address
    wr(A_EN, 8'h3C); rd(A_EN, v); check("R9 en readback", v, 8'h3C);
    wr(A_NONE, 8'hFF); rd(A_NONE, v); check("R9 addr3 reads zero", v, 8'h00);
    rd(A_FLAG, v); check("R9 addr3 write ignored", v, 8'h00);

    // R8 pull select
    wr(A_POL, 8'hA5);
    check("R8 pull_dn", pull_dn, 8'hA5);
    check("R8 pull_up", pull_up, 8'h5A);

    // vector table (R3 edge select, R6 masking)
    foreach (VECS[k]) begin
      pin = VECS[k].start;
      cycles(5);
      wr(A_POL, VECS[k].pol);
      wr(A_EN, VECS[k].en);
      wr(A_FLAG, 8'hFF);
      cycles(2);
      pin = VECS[k].fin;
      cycles(5);
      rd(A_FLAG, v);
      check($sformatf("R3 vec%0d flags", k), v, VECS[k].exp_flag);
      check($sformatf("R6 vec%0d irq", k), irq, VECS[k].exp_irq);
    end

    // settle to known state: all pins low, all flags clear
    pin = '0;
    cycles(5);
    wr(A_FLAG, 8'hFF);
    cycles(2);

    // R7 polarity flips with steady pins
    wr(A_POL, 8'hFF);
    cycles(3);
    wr(A_POL, 8'h00);
    cycles(3);
    rd(A_FLAG, v); check("R7 polarity change sets nothing", v, 8'h00);

    // R2 latency and R6 irq one cycle later
    wr(A_POL, 8'h01);
    wr(A_EN, 8'h01);
    cycles(1);
    pin[0] = 1'b1;          // before edge k
    cycles(2);              // after edges k, k+1
    rd(A_FLAG, v); check("R2 not yet set after k+1", v, 8'h00);
    cycles(1);              // after k+2
    rd(A_FLAG, v); check("R2 set after k+2", v, 8'h01);
    check("R6 irq still low at k+2", irq, 0);
    cycles(1);
    check("R6 irq high at k+3", irq, 1);

    // R10 sticky after pin returns (falling is inactive here)
    pin[0] = 1'b0;
    cycles(5);
    rd(A_FLAG, v); check("R10 flag sticky", v, 8'h01);

    // R5 clear and active edge in the same cycle
    pin[0] = 1'b1;
    cycles(2);
    wr(A_FLAG, 8'h01);      // lands on edge k+2 with the hit
    rd(A_FLAG, v); check("R5 set wins", v, 8'h01);

    // R4 write-0 keeps, write-1 clears
    cycles(3);
    wr(A_FLAG, 8'h00);
    rd(A_FLAG, v); check("R4 write zero keeps", v, 8'h01);
    wr(A_FLAG, 8'h01);
    rd(A_FLAG, v); check("R4 write one clears", v, 8'h00);
    cycles(1);
    check("R6 irq drops after clear", irq, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule